// File: doc/BRIEF.md
# Core-Count Turbo Ratio Controller

This block picks the clock multiplier a multicore processor runs at. It looks at how many cores are currently busy, the base multiplier, and a few permission flags (turbo allowed, temperature within limits, supply reported steady). From these it forms a target ratio. Lightly loaded parts get the larger boost and heavily loaded parts get the smaller one. Parts sold with an open multiplier may also replace that rule with their own ratio for each busy-core count, and may set their own base.

The selected ratio follows its target one step at a time. A step is taken only on an evaluation tick, which arrives once every `EVAL_CYCLES` clocks. A loss of any permission flag sends the output straight back to base on the next clock, without waiting for a tick. A registered strobe marks each cycle in which the output takes a new value. The clock synthesizer, the regulator and the sensors that feed these flags are outside the block.

Top module: `turbo_ratio_ctrl`

## Requirements
- R1: With two or more cores busy, and boost permitted on a part with a fixed multiplier, the target is base plus one.
- R2: With one busy core, or with a busy count of zero (which is handled as one), the target on a fixed part is base plus two.
- R3: While `thermal_ok` or `volt_ok` is low, `ratio_out` equals the base on the clock edge that follows, even when no tick is due.
- R4: While `turbo_en` is low, `ratio_out` equals the base on the next clock edge and stays there.
- R5: With `unlocked` high, the target for busy count k is the override field `ovr_ratio[k*RATIO_W-1 -: RATIO_W]`. A count of zero uses field 1, and counts above `MAX_CORES` use the last field. A field value of zero selects the R1/R2 rule instead. A field below base is raised to base.
- R6: With `unlocked` low, the base is the parameter `FUSED_BASE` and `base_ratio` has no effect. With `unlocked` high, the base is `base_ratio`.
- R7: Apart from the cases in R3 and R4, `ratio_out` changes only on an evaluation tick, and then by exactly one toward the target. Ticks fall on clock edge `EVAL_CYCLES`, `2*EVAL_CYCLES`, ... after reset is released.
- R8: `ratio_chg` is high in exactly those cycles in which `ratio_out` shows a value different from the one it held in the cycle before.
- R9: During reset `ratio_out` equals `FUSED_BASE` and `ratio_chg` is low.
- R10: A target above `2**RATIO_W-1` saturates at `2**RATIO_W-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_cores | input | $clog2(MAX_CORES+1) | Number of busy cores |
| base_ratio | input | RATIO_W | Base multiplier, used on unlocked parts |
| turbo_en | input | 1 | Boost allowed |
| thermal_ok | input | 1 | Temperature within limits |
| volt_ok | input | 1 | Supply reported stable |
| unlocked | input | 1 | Part has an open multiplier |
| ovr_ratio | input | MAX_CORES*RATIO_W | Per-count target ratios, field k-1 for k busy cores |
| ratio_out | output | RATIO_W | Selected multiplier |
| ratio_chg | output | 1 | One-cycle strobe when ratio_out changes |

## Verification
A permission drop takes effect after one register. It therefore shows on the falling edge that follows the next rising edge, and the bench checks it at exactly that edge. A busy-count or override change shows only after the next tick, so its settled value is checked once enough whole intervals have passed to cover every step. In between, a behavioural model counts ticks from reset release and is compared with `ratio_out` and `ratio_chg` on every falling edge. This also confirms that nothing moves between ticks and that the strobe lines up with the cycle of each change.

// File: rtl/turbo_pkg.sv
package turbo_pkg;

  // Busy count as used for selection: zero behaves as one, large counts clamp.
  function automatic int norm_count(input int raw, input int max_c);
    if (raw <= 0) return 1;
    if (raw > max_c) return max_c;
    return raw;
  endfunction

  // Default boost in bins for a normalised busy count.
  function automatic int default_bump(input int cnt);
    return (cnt == 1) ? 2 : 1;
  endfunction

  // Clamp a ratio into [lo, 2**w-1].
  function automatic int clamp_ratio(input int v, input int lo, input int w);
    int top;
    top = (1 << w) - 1;
    if (v < lo) v = lo;
    if (v > top) v = top;
    return v;
  endfunction

endpackage

// File: rtl/turbo_target_sel.sv
module turbo_target_sel
  import turbo_pkg::*;
#(
  parameter int RATIO_W   = 8,
  parameter int MAX_CORES = 4,
  localparam int CORE_W   = $clog2(MAX_CORES + 1),
  localparam int IDX_W    = (MAX_CORES > 1) ? $clog2(MAX_CORES) : 1
) (
  input  logic [CORE_W-1:0]            active_cores,
  input  logic [RATIO_W-1:0]           eff_base,
  input  logic                         unlocked,
  input  logic [MAX_CORES*RATIO_W-1:0] ovr_ratio,
  output logic [RATIO_W-1:0]           target
);

  logic [RATIO_W-1:0] ovr_arr [MAX_CORES];

  for (genvar g = 0; g < MAX_CORES; g++) begin : g_unpack
    assign ovr_arr[g] = ovr_ratio[g*RATIO_W +: RATIO_W];
  end

  logic [IDX_W-1:0]   sel_idx;
  logic [RATIO_W-1:0] sel_ovr;
  int                 cnt_n;
  int                 raw_t;

  always_comb begin
    cnt_n   = norm_count(int'(active_cores), MAX_CORES);
    sel_idx = IDX_W'(cnt_n - 1);
    sel_ovr = ovr_arr[sel_idx];
    if (unlocked && (sel_ovr != '0)) raw_t = int'(sel_ovr);
    else                             raw_t = int'(eff_base) + default_bump(cnt_n);
    target = RATIO_W'(clamp_ratio(raw_t, int'(eff_base), RATIO_W));
  end

endmodule

// File: rtl/turbo_eval_timer.sv
module turbo_eval_timer #(
  parameter int EVAL_CYCLES = 16,
  localparam int CNT_W      = (EVAL_CYCLES > 1) ? $clog2(EVAL_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(EVAL_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/turbo_ratio_stepper.sv
module turbo_ratio_stepper #(
  parameter int RATIO_W    = 8,
  parameter int FUSED_BASE = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               force_base,
  input  logic [RATIO_W-1:0] eff_base,
  input  logic [RATIO_W-1:0] target,
  output logic [RATIO_W-1:0] ratio_out,
  output logic               ratio_chg
);

  logic [RATIO_W-1:0] nxt;

  always_comb begin
    nxt = ratio_out;
    if (force_base) begin
      nxt = eff_base;
    end else if (tick) begin
      if (ratio_out < target)      nxt = ratio_out + 1'b1;
      else if (ratio_out > target) nxt = ratio_out - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_out <= RATIO_W'(FUSED_BASE);
      ratio_chg <= 1'b0;
    end else begin
      ratio_out <= nxt;
      ratio_chg <= (nxt != ratio_out);
    end
  end

endmodule

// File: rtl/turbo_ratio_ctrl.sv
module turbo_ratio_ctrl #(
  parameter int RATIO_W     = 8,
  parameter int MAX_CORES   = 4,
  parameter int EVAL_CYCLES = 16,
  parameter int FUSED_BASE  = 24,
  localparam int CORE_W     = $clog2(MAX_CORES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CORE_W-1:0]            active_cores,
  input  logic [RATIO_W-1:0]           base_ratio,
  input  logic                         turbo_en,
  input  logic                         thermal_ok,
  input  logic                         volt_ok,
  input  logic                         unlocked,
  input  logic [MAX_CORES*RATIO_W-1:0] ovr_ratio,
  output logic [RATIO_W-1:0]           ratio_out,
  output logic                         ratio_chg
);

  // Named internal events, exposed for the bound checker.
  logic [RATIO_W-1:0] eff_base;
  logic [RATIO_W-1:0] target;
  logic               boost_ok;
  logic               force_base;
  logic               tick;

  assign eff_base   = unlocked ? base_ratio : RATIO_W'(FUSED_BASE);
  assign boost_ok   = turbo_en & thermal_ok & volt_ok;
  assign force_base = ~boost_ok;

  turbo_target_sel #(
    .RATIO_W   (RATIO_W),
    .MAX_CORES (MAX_CORES)
  ) u_sel (
    .active_cores (active_cores),
    .eff_base     (eff_base),
    .unlocked     (unlocked),
    .ovr_ratio    (ovr_ratio),
    .target       (target)
  );

  turbo_eval_timer #(
    .EVAL_CYCLES (EVAL_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  turbo_ratio_stepper #(
    .RATIO_W    (RATIO_W),
    .FUSED_BASE (FUSED_BASE)
  ) u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .force_base (force_base),
    .eff_base   (eff_base),
    .target     (target),
    .ratio_out  (ratio_out),
    .ratio_chg  (ratio_chg)
  );

endmodule

// File: rtl/turbo_ratio_ctrl_chk.sv
module turbo_ratio_ctrl_chk #(
  parameter int RATIO_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               turbo_en,
  input logic               thermal_ok,
  input logic               volt_ok,
  input logic               tick,
  input logic               force_base,
  input logic [RATIO_W-1:0] eff_base,
  input logic [RATIO_W-1:0] target,
  input logic [RATIO_W-1:0] ratio_out,
  input logic               ratio_chg
);

  a_r3_fault_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    !(thermal_ok && volt_ok) |=> (ratio_out == $past(eff_base)));

  a_r4_turbo_off_base: assert property (@(posedge clk) disable iff (!rst_n)
    !turbo_en |=> (ratio_out == $past(eff_base)));

  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_base && !tick) |=> $stable(ratio_out));

  a_r7_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_base && tick && (ratio_out < target)) |=>
      (ratio_out == $past(ratio_out) + 1'b1));

  a_r7_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!force_base && tick && (ratio_out > target)) |=>
      (ratio_out == $past(ratio_out) - 1'b1));

  a_r8_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_out != $past(ratio_out)) |-> ratio_chg);

  a_r8_strobe_only_change: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_chg |-> (ratio_out != $past(ratio_out)));

  a_r5_target_floor: assert property (@(posedge clk) disable iff (!rst_n)
    target >= eff_base);

endmodule

bind turbo_ratio_ctrl turbo_ratio_ctrl_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .turbo_en   (turbo_en),
  .thermal_ok (thermal_ok),
  .volt_ok    (volt_ok),
  .tick       (tick),
  .force_base (force_base),
  .eff_base   (eff_base),
  .target     (target),
  .ratio_out  (ratio_out),
  .ratio_chg  (ratio_chg)
);

// File: tb/turbo_ratio_ctrl_bench.sv
module turbo_ratio_ctrl_bench;

  localparam int RW    = 8;
  localparam int NC    = 4;
  localparam int EVAL  = 16;
  localparam int FUSED = 24;
  localparam int CW    = $clog2(NC + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [CW-1:0]   active_cores = '0;
  logic [RW-1:0]   base_ratio = 8'd30;
  logic            turbo_en = 1'b1;
  logic            thermal_ok = 1'b1;
  logic            volt_ok = 1'b1;
  logic            unlocked = 1'b0;
  logic [NC*RW-1:0] ovr_ratio = '0;
  logic [RW-1:0]   ratio_out;
  logic            ratio_chg;

  always #2 clk = ~clk;  // 250 MHz

  turbo_ratio_ctrl #(
    .RATIO_W(RW), .MAX_CORES(NC), .EVAL_CYCLES(EVAL), .FUSED_BASE(FUSED)
  ) u_turbo_ratio_ctrl (
    .clk(clk), .rst_n(rst_n), .active_cores(active_cores),
    .base_ratio(base_ratio), .turbo_en(turbo_en), .thermal_ok(thermal_ok),
    .volt_ok(volt_ok), .unlocked(unlocked), .ovr_ratio(ovr_ratio),
    .ratio_out(ratio_out), .ratio_chg(ratio_chg)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R9";

  // Behavioural reference: integers only, restated from the requirements.
  int m_ratio = FUSED;
  int m_chg   = 0;
  int m_since = 0;  // clock edges since reset release

  function automatic int ref_target();
    int base, k, f, t;
    base = unlocked ? int'(base_ratio) : FUSED;                 // R6
    k = int'(active_cores);
    if (k == 0) k = 1;                                           // R2
    if (k > NC) k = NC;
    f = int'(ovr_ratio[k*RW-1 -: RW]);                           // R5
    if (unlocked && f != 0) t = f;
    else t = base + ((k == 1) ? 2 : 1);                          // R1 R2
    if (t < base) t = base;
    if (t > 255) t = 255;                                        // R10
    return t;
  endfunction

  always @(posedge clk) begin
    int base, nxt, tgt;
    if (!rst_n) begin
      m_ratio = FUSED; m_chg = 0; m_since = 0;
    end else begin
      m_since = m_since + 1;
      base = unlocked ? int'(base_ratio) : FUSED;
      nxt = m_ratio;
      if (!(turbo_en && thermal_ok && volt_ok)) nxt = base;      // R3 R4
      else if (m_since % EVAL == 0) begin                        // R7
        tgt = ref_target();
        if (m_ratio < tgt) nxt = m_ratio + 1;
        else if (m_ratio > tgt) nxt = m_ratio - 1;
      end
      m_chg = (nxt != m_ratio) ? 1 : 0;                          // R8
      m_ratio = nxt;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle compare against the model on every falling edge.
  always @(negedge clk) begin
    check({"R7 ", cur_req}, int'(ratio_out), m_ratio);
    check("R8", int'(ratio_chg), m_chg);
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    check("R9", int'(ratio_out), FUSED);
    check("R9", int'(ratio_chg), 0);
    rst_n = 1'b1;

    // Fixed part, one busy core, base_ratio ignored (R6, R2)
    cur_req = "R2"; active_cores = 3'd1;
    cyc(EVAL - 1);
    check("R7", int'(ratio_out), FUSED);
    cyc(1);
    check("R7", int'(ratio_out), FUSED + 1);
    cyc(2 * EVAL);
    check("R2", int'(ratio_out), FUSED + 2);
    check("R6", int'(ratio_out), FUSED + 2);

    cur_req = "R1"; active_cores = 3'd3;
    cyc(2 * EVAL);
    check("R1", int'(ratio_out), FUSED + 1);

    cur_req = "R2"; active_cores = 3'd0;
    cyc(2 * EVAL);
    check("R2", int'(ratio_out), FUSED + 2);

    cur_req = "R3"; thermal_ok = 1'b0;
    cyc(1);
    check("R3", int'(ratio_out), FUSED);
    check("R8", int'(ratio_chg), 1);
    cyc(1);
    check("R8", int'(ratio_chg), 0);
    thermal_ok = 1'b1;
    cyc(3 * EVAL);
    check("R2", int'(ratio_out), FUSED + 2);
    volt_ok = 1'b0;
    cyc(1);
    check("R3", int'(ratio_out), FUSED);
    volt_ok = 1'b1;
    cyc(3 * EVAL);

    cur_req = "R4"; turbo_en = 1'b0;
    cyc(1);
    check("R4", int'(ratio_out), FUSED);
    cyc(3 * EVAL);
    check("R4", int'(ratio_out), FUSED);
    turbo_en = 1'b1;

    // Unlocked part with overrides (R5, R6)
    cur_req = "R5"; unlocked = 1'b1; base_ratio = 8'd26;
    ovr_ratio = {8'd20, 8'd27, 8'd28, 8'd30};
    active_cores = 3'd1;
    cyc(8 * EVAL);
    check("R5", int'(ratio_out), 30);
    active_cores = 3'd2;
    cyc(3 * EVAL);
    check("R5", int'(ratio_out), 28);
    active_cores = 3'd4;
    cyc(3 * EVAL);
    check("R5", int'(ratio_out), 26);
    active_cores = 3'd7;
    cyc(2 * EVAL);
    check("R5", int'(ratio_out), 26);
    active_cores = 3'd3;
    cyc(2 * EVAL);
    check("R5", int'(ratio_out), 27);

    cur_req = "R6"; turbo_en = 1'b0;
    cyc(1);
    check("R6", int'(ratio_out), 26);

    // Saturation: zero field selects default rule (R10)
    cur_req = "R10"; base_ratio = 8'd254; ovr_ratio = '0; active_cores = 3'd1;
    cyc(1);
    check("R6", int'(ratio_out), 254);
    turbo_en = 1'b1;
    cyc(4 * EVAL);
    check("R10", int'(ratio_out), 255);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule